// File: doc/BRIEF.md
# Unrecoverable Error Aggregation Controller

This block gathers unrecoverable-error events from 48 internal units into sticky status flags. Each flag has a mask bit beside it. Whenever any flag is set and not masked, the block raises a level interrupt to the host and a separate level alert to a management controller. For as long as that condition lasts, it also drives the online-control bit of every unit to offline.

Software reaches six 32-bit registers over a simple word-addressed register bus. The six registers are two status words, two mask words and two online words. Status flags are cleared by writing ones. Offline is sticky: once an unmasked error has forced the units offline, they stay offline after the error is cleared. They return online only when software writes their online bits back to one.

Top module: `ue_aggregator`

## Requirements
- R1: After reset, all status bits and all mask bits are zero, every used online bit is one, and both `host_irq` and `mgmt_alert` are low.
- R2: A one on `err_set[i]` in a cycle sets status bit i at the next clock edge. The bit then stays set until software clears it. A status bit never becomes one without a pulse.
- R3: Writing a status word clears each status bit whose data bit is one. Data bits that are zero leave their status bits unchanged.
- R4: If a hardware pulse and a software clear hit the same status bit in the same cycle, the bit ends at one.
- R5: A mask bit of one stops its status bit from raising `host_irq` or `mgmt_alert` and from forcing units offline. Clearing the mask bit while the status bit is still set raises the notification.
- R6: `host_irq` and `mgmt_alert` are identical level outputs. They are high in every cycle in which at least one status bit is set with its mask bit zero. They fall only after a register write clears or masks the last such bit.
- R7: In every cycle that starts with an unmasked set status bit, all online bits are loaded with zero at the clock edge. Writes of ones to the online words have no effect during such a cycle.
- R8: When no unmasked error is pending, a write to an online word loads its bits. Without such a write, the online bits hold their value, so units forced offline stay offline after their errors are cleared.
- R9: Source i with i < 32 is bit i of word 40 (status) and bit i of word 42 (mask). Source 32+j is bit j of word 41 and bit j of word 43. Unit online bits use the same positions in words 44 and 45, and `unit_online[k]` is the online bit of source k.
- R10: `reg_rdata` shows the addressed register in the cycle after `reg_rd` is high. It is zero after a read of any address other than 40 to 45, and zero after a cycle with no read.
- R11: Bits 31:16 of words 41, 43 and 45 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_set | input | 48 | One-cycle error pulses, one per unit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| host_irq | output | 1 | Host interrupt level |
| mgmt_alert | output | 1 | Management controller alert level |
| unit_online | output | 48 | Online control, one bit per unit |

## Verification
Some properties are checked on every cycle. A pulse always sets its status bit. No status bit appears without a pulse. A write-one clear takes effect unless a pulse collides with it. A pending unmasked error empties the online bits, and the online bits hold when nothing writes them. The interrupt falls only after a bus write. Unmapped and reserved read data are zero.

Other behaviours need the bench's scenarios: the register offsets and bit positions, the reset values, and the masking of a source in the high word. The bench also shows that units stay offline after the error is cleared until software rewrites them, and that unmasking a held flag raises the interrupt. A behavioural reference model compares the outputs on every cycle through random traffic.

// File: rtl/ue_pkg.sv
package ue_pkg;
  typedef enum logic [1:0] {
    RK_NONE   = 2'd0,
    RK_STATUS = 2'd1,
    RK_MASK   = 2'd2,
    RK_ONLINE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/ue_regdec.sv
module ue_regdec
  import ue_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BASE    = 40,
  parameter int N_WORDS = 2,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  // Three register groups of N_WORDS each, laid out back to back from BASE.
  always_comb begin
    hit  = 1'b0;
    kind = RK_NONE;
    idx  = '0;
    for (int k = 0; k < 3; k++) begin
      if (addr >= ADDR_W'(BASE + k * N_WORDS) &&
          addr <  ADDR_W'(BASE + (k + 1) * N_WORDS)) begin
        hit  = 1'b1;
        kind = reg_kind_e'(k + 1);
        idx  = IDX_W'(addr - ADDR_W'(BASE + k * N_WORDS));
      end
    end
  end
endmodule

// File: rtl/ue_status_bank.sv
module ue_status_bank #(
  parameter int N_SRC = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] err_set,
  input  logic [N_SRC-1:0] clr_vec,
  input  logic [N_SRC-1:0] mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  output logic [N_SRC-1:0] status_q,
  output logic [N_SRC-1:0] mask_q,
  output logic             pending
);
  // Set dominates clear: hardware pulses are ORed in after the clear.
  function automatic logic [N_SRC-1:0] status_next(
    input logic [N_SRC-1:0] cur, input logic [N_SRC-1:0] clr,
    input logic [N_SRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [N_SRC-1:0] merge_bits(
    input logic [N_SRC-1:0] cur, input logic [N_SRC-1:0] we,
    input logic [N_SRC-1:0] d);
    return (cur & ~we) | (d & we);
  endfunction

  logic [N_SRC-1:0] unmasked_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_next(status_q, clr_vec, err_set);
      mask_q   <= merge_bits(mask_q, mask_we, mask_wdata);
    end
  end

  assign unmasked_vec = status_q & ~mask_q;
  assign pending      = |unmasked_vec;

  assert_set_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(err_set)) == $past(err_set)));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(err_set)) == '0));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((status_q & $past(clr_vec) & ~$past(err_set)) == '0));
endmodule

// File: rtl/ue_online_ctrl.sv
module ue_online_ctrl #(
  parameter int N_SRC = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic [N_SRC-1:0] we,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] online_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       online_q <= '1;
    else if (pending) online_q <= '0;
    else              online_q <= (online_q & ~we) | (wdata & we);
  end

  assert_forced_offline_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (online_q == '0));

  assert_online_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && we == '0) |=> (online_q == $past(online_q)));
endmodule

// File: rtl/ue_aggregator.sv
module ue_aggregator
  import ue_pkg::*;
#(
  parameter int N_SRC  = 48,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int BASE   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  err_set,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              host_irq,
  output logic              mgmt_alert,
  output logic [N_SRC-1:0]  unit_online
);
  localparam int N_WORDS = (N_SRC + DATA_W - 1) / DATA_W;
  localparam int PAD_W   = N_WORDS * DATA_W;
  localparam int IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int LAST_USED = N_SRC - (N_WORDS - 1) * DATA_W;
  localparam logic [DATA_W-1:0] RSVD_MASK = ~((DATA_W'(1) << LAST_USED) - DATA_W'(1));

  function automatic logic [PAD_W-1:0] pad_vec(input logic [N_SRC-1:0] v);
    logic [PAD_W-1:0] p;
    p = '0;
    p[N_SRC-1:0] = v;
    return p;
  endfunction

  logic              dec_hit;
  reg_kind_e         dec_kind;
  logic [IDX_W-1:0]  dec_idx;
  logic [PAD_W-1:0]  we_stat_pad, we_mask_pad, we_onl_pad;
  logic [PAD_W-1:0]  wdata_pad;
  logic [N_SRC-1:0]  status_q, mask_q, clr_vec, mask_we, onl_we, wdata_vec;
  logic              pending;
  logic [DATA_W-1:0] rd_word;
  logic [PAD_W-1:0]  rd_src;

  ue_regdec #(.ADDR_W(ADDR_W), .BASE(BASE), .N_WORDS(N_WORDS)) u_dec (
    .addr(reg_addr), .hit(dec_hit), .kind(dec_kind), .idx(dec_idx));

  assign wdata_pad = {N_WORDS{reg_wdata}};

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word_we
    logic sel;
    assign sel = reg_wr && dec_hit && (dec_idx == IDX_W'(w));
    assign we_stat_pad[w*DATA_W +: DATA_W] = {DATA_W{sel && dec_kind == RK_STATUS}};
    assign we_mask_pad[w*DATA_W +: DATA_W] = {DATA_W{sel && dec_kind == RK_MASK}};
    assign we_onl_pad[w*DATA_W +: DATA_W]  = {DATA_W{sel && dec_kind == RK_ONLINE}};
  end

  assign wdata_vec = wdata_pad[N_SRC-1:0];
  assign clr_vec   = we_stat_pad[N_SRC-1:0] & wdata_vec;
  assign mask_we   = we_mask_pad[N_SRC-1:0];
  assign onl_we    = we_onl_pad[N_SRC-1:0];

  ue_status_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .err_set(err_set), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_wdata(wdata_vec),
    .status_q(status_q), .mask_q(mask_q), .pending(pending));

  ue_online_ctrl #(.N_SRC(N_SRC)) u_onl (
    .clk(clk), .rst_n(rst_n), .pending(pending), .we(onl_we),
    .wdata(wdata_vec), .online_q(unit_online));

  always_comb begin
    case (dec_kind)
      RK_STATUS: rd_src = pad_vec(status_q);
      RK_MASK:   rd_src = pad_vec(mask_q);
      RK_ONLINE: rd_src = pad_vec(unit_online);
      default:   rd_src = '0;
    endcase
    rd_word = rd_src[int'(dec_idx)*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  reg_rdata <= '0;
    else if (reg_rd && dec_hit)  reg_rdata <= rd_word;
    else                         reg_rdata <= '0;
  end

  assign host_irq   = pending;
  assign mgmt_alert = pending;

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !dec_hit) |=> (reg_rdata == '0));

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && dec_hit && dec_idx == IDX_W'(N_WORDS - 1)) |=> ((reg_rdata & RSVD_MASK) == '0));

  assert_irq_falls_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(reg_wr));
endmodule

// File: tb/sim_ue_aggregator.sv
`timescale 1ns/1ps
module sim_ue_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] err_set = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_irq, mgmt_alert;
  logic [47:0] unit_online;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ue_aggregator u0 (.clk(clk), .rst_n(rst_n), .err_set(err_set), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_irq(host_irq), .mgmt_alert(mgmt_alert), .unit_online(unit_online));

  // Behavioural reference model
  logic [47:0] m_stat, m_mask, m_onl;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'd40: return m_stat[31:0];
      8'd41: return {16'h0, m_stat[47:32]};
      8'd42: return m_mask[31:0];
      8'd43: return {16'h0, m_mask[47:32]};
      8'd44: return m_onl[31:0];
      8'd45: return {16'h0, m_onl[47:32]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_onl = '1; m_rdata = '0;
    end else begin
      bit pend;
      logic [47:0] clr;
      pend = |(m_stat & ~m_mask);
      m_rdata = reg_rd ? m_read(reg_addr) : 32'h0;
      clr = '0;
      if (reg_wr && reg_addr == 8'd40) clr[31:0] = reg_wdata;
      if (reg_wr && reg_addr == 8'd41) clr[47:32] = reg_wdata[15:0];
      if (reg_wr && reg_addr == 8'd42) m_mask[31:0] = reg_wdata;
      if (reg_wr && reg_addr == 8'd43) m_mask[47:32] = reg_wdata[15:0];
      if (pend) m_onl = '0;
      else begin
        if (reg_wr && reg_addr == 8'd44) m_onl[31:0] = reg_wdata;
        if (reg_wr && reg_addr == 8'd45) m_onl[47:32] = reg_wdata[15:0];
      end
      m_stat = (m_stat & ~clr) | err_set;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R6, R7, R8, R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit mp;
      mp = |(m_stat & ~m_mask);
      check("R6 host_irq vs model", 64'(host_irq), 64'(mp));
      check("R6 mgmt_alert vs model", 64'(mgmt_alert), 64'(mp));
      check("R7/R8 unit_online vs model", 64'(unit_online), 64'(m_onl));
      check("R10 reg_rdata vs model", 64'(reg_rdata), 64'(m_rdata));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [47:0] v);
    @(negedge clk); err_set = v;
    @(negedge clk); err_set = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'd40, d); check("R1 status lo", 64'(d), 64'h0);
    rd(8'd41, d); check("R1 status hi", 64'(d), 64'h0);
    rd(8'd42, d); check("R1 mask lo", 64'(d), 64'h0);
    rd(8'd43, d); check("R1 mask hi", 64'(d), 64'h0);
    rd(8'd44, d); check("R1 online lo", 64'(d), 64'hffffffff);
    rd(8'd45, d); check("R1 online hi", 64'(d), 64'h0000ffff);
    check("R1 irq low", 64'(host_irq), 64'h0);
    // R2 sticky set, R6 notification, R7 offline
    pulse(48'h20);
    check("R2 irq after pulse", 64'(host_irq), 64'h1);
    check("R6 alert after pulse", 64'(mgmt_alert), 64'h1);
    @(negedge clk);
    check("R7 units offline", 64'(unit_online), 64'h0);
    rd(8'd40, d); check("R9 R2 status lo bit5", 64'(d), 64'h20);
    wr(8'd44, 32'hffffffff);
    rd(8'd44, d); check("R7 online write ignored", 64'(d), 64'h0);
    // R3 write-one-to-clear
    wr(8'd40, 32'h0);
    rd(8'd40, d); check("R3 zero write keeps bit", 64'(d), 64'h20);
    wr(8'd40, 32'h20);
    check("R3 R6 irq drops after clear", 64'(host_irq), 64'h0);
    rd(8'd40, d); check("R3 status cleared", 64'(d), 64'h0);
    check("R8 offline persists", 64'(unit_online), 64'h0);
    wr(8'd44, 32'hffffffff); wr(8'd45, 32'hffffffff);
    check("R8 online restored", 64'(unit_online), 64'hffffffffffff);
    rd(8'd45, d); check("R11 online hi reserved", 64'(d), 64'h0000ffff);
    // R4 set wins over clear
    pulse(48'h80);
    @(negedge clk); err_set = 48'h80; reg_wr = 1; reg_addr = 8'd40; reg_wdata = 32'h80;
    @(negedge clk); err_set = '0; reg_wr = 0;
    rd(8'd40, d); check("R4 set beats clear", 64'(d), 64'h80);
    wr(8'd40, 32'h80);
    wr(8'd44, 32'hffffffff); wr(8'd45, 32'hffffffff);
    // R5 masking, high word
    wr(8'd43, 32'hffffffff);
    rd(8'd43, d); check("R11 mask hi reserved", 64'(d), 64'h0000ffff);
    wr(8'd43, 32'h2);
    pulse(48'h2_0000_0000);
    @(negedge clk); @(negedge clk);
    check("R5 masked no irq", 64'(host_irq), 64'h0);
    check("R5 masked stays online", 64'(unit_online), 64'hffffffffffff);
    rd(8'd41, d); check("R9 src33 at word41 bit1", 64'(d), 64'h2);
    wr(8'd43, 32'h0);
    check("R5 unmask raises irq", 64'(host_irq), 64'h1);
    wr(8'd41, 32'hffffffff);
    rd(8'd41, d); check("R3 R11 status hi cleared", 64'(d), 64'h0);
    wr(8'd44, 32'hffffffff); wr(8'd45, 32'hffffffff);
    // R5 low word mask
    wr(8'd42, 32'h8);
    pulse(48'h8);
    check("R5 low mask no irq", 64'(host_irq), 64'h0);
    rd(8'd42, d); check("R9 mask lo readback", 64'(d), 64'h8);
    wr(8'd40, 32'h8); wr(8'd42, 32'h0);
    // R10 unmapped reads and latency
    rd(8'd10, d); check("R10 unmapped 10", 64'(d), 64'h0);
    rd(8'd46, d); check("R10 unmapped 46", 64'(d), 64'h0);
    rd(8'd39, d); check("R10 unmapped 39", 64'(d), 64'h0);
    rd(8'd44, d); check("R10 one-cycle read", 64'(d), 64'hffffffff);
    @(negedge clk); check("R10 zero with no read", 64'(reg_rdata), 64'h0);
    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      err_set = ($urandom % 6 == 0) ? (48'h1 << ($urandom % 48)) : '0;
      reg_wr = ($urandom % 3 == 0);
      reg_rd = ($urandom % 2 == 0);
      reg_addr = 8'(38 + $urandom % 10);
      reg_wdata = ($urandom % 2 == 0) ? 32'hffffffff : $urandom;
    end
    @(negedge clk); err_set = '0; reg_wr = 0; reg_rd = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule